// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block computes the value of an arithmetic expression written in reverse Polish (postfix) order. Tokens arrive one at a time over a valid/ready handshake. A number token goes onto an internal last-in-first-out stack. An operator token takes the top two stack values, combines them and places the result back on the stack. A terminator token ends the expression, and the block then returns the single value left on the stack.

A small control state machine runs each operator as four fixed steps: accept the token, pop the right-hand value, pop the left-hand value, then push the result. The input stays not-ready during the last three steps. The block flags three faults with one-cycle pulses: pushing onto a full stack, an operator with too few values, and a terminator with the wrong number of values left. After any result or fault the stack is emptied, so the next token starts a fresh expression.

For example, the token stream `3 4 + 5 *` evaluates to (3+4)*5 = 35.

Top module: `pfx_eval`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tok_ready` is 1, the stack is empty, and `res_valid` and all three error outputs are 0.
- R2: A number token (`tok_kind` = 2'b00) that is accepted while the stack holds fewer than DEPTH values is pushed in that same cycle, and `tok_ready` stays 1.
- R3: A terminator token (`tok_kind` = 2'b10) that is accepted with exactly one value on the stack raises `res_valid` for one cycle, starting on the edge after acceptance, with `res_data` equal to that value.
- R4: An operator token (`tok_kind` = 2'b01) uses `tok_data[1:0]` to pick the operation: 00 adds, 01 subtracts, 10 and 11 multiply. The first value popped is the right-hand operand, so subtraction gives left minus right. Results wrap modulo 2^16, and the stack ends up one value shorter.
- R5: A number token accepted while the stack already holds DEPTH values raises `err_overflow` for one cycle on the next edge.
- R6: An operator token accepted with fewer than two values on the stack raises `err_underflow` for one cycle on the next edge.
- R7: A terminator token accepted with any stack depth other than one raises `err_malformed` for one cycle on the next edge.
- R8: After an operator is accepted with at least two values on the stack, `tok_ready` is 0 for exactly three cycles and then returns to 1.
- R9: A result or any error empties the stack, so the next expression starts with no leftover values.
- R10: A token of the reserved kind 2'b11 is accepted and discarded. It leaves the stack unchanged and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tok_valid | input | 1 | A token is offered |
| tok_kind | input | 2 | Token kind: 00 number, 01 operator, 10 terminator, 11 reserved |
| tok_data | input | 16 | Number value, or operation select in bits [1:0] |
| tok_ready | output | 1 | The block can take a token this cycle |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds the expression value |
| res_data | output | 16 | Value of the expression |
| err_overflow | output | 1 | One-cycle pulse: a push was attempted on a full stack |
| err_underflow | output | 1 | One-cycle pulse: an operator arrived with fewer than two values |
| err_malformed | output | 1 | One-cycle pulse: the terminator found a depth other than one |

## Verification
The result pulse and every error pulse appear on the first edge after the token that causes them, so the bench samples them at the falling edge that directly follows the accepting rising edge. For a valid operator, the bench samples `tok_ready` at each of the next four falling edges and expects 0, 0, 0, 1. It never drives a new token until `tok_ready` has returned to 1, which makes each operator's result visible only through the value the terminator later returns. The assertions follow the same timing: they check the fault pulses one cycle after acceptance, and they check that the stack is exactly one value shorter four cycles after an operator is accepted.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int DATA_W = 16;

    // Token kinds carried on tok_kind
    typedef enum logic [1:0] {
        TK_NUM  = 2'b00,
        TK_OPER = 2'b01,
        TK_TERM = 2'b10,
        TK_RSVD = 2'b11
    } tok_kind_e;

    // Operation chosen by the arithmetic unit
    typedef enum logic [1:0] {
        SEL_ADD,
        SEL_SUB,
        SEL_MUL
    } alu_sel_e;

    // Control sequence of the evaluator
    typedef enum logic [1:0] {
        ST_TAKE,
        ST_POP_R,
        ST_POP_L,
        ST_PUSH
    } ctrl_state_e;

    // Error pulses, grouped so they travel together
    typedef struct packed {
        logic ovf;
        logic unf;
        logic bad;
    } err_t;

    // Map operator payload bits to an operation (10 and 11 both multiply)
    function automatic alu_sel_e op_decode(input logic [1:0] code);
        unique case (code)
            2'b00:   return SEL_ADD;
            2'b01:   return SEL_SUB;
            default: return SEL_MUL;
        endcase
    endfunction

endpackage

// File: rtl/pfx_stack.sv
module pfx_stack #(
    parameter int W     = pfx_pkg::DATA_W,
    parameter int DEPTH = 16,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          clr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [DW-1:0] depth,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [DW-1:0] depth_q;
    logic [DW-1:0] top_m1;

    // One register per entry, written only when it is the next free slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (push && depth_q == DW'(i)) begin
                mem[i] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            depth_q <= '0;
        end else if (push) begin
            depth_q <= depth_q + DW'(1);
        end else if (pop) begin
            depth_q <= depth_q - DW'(1);
        end
    end

    assign top_m1 = depth_q - DW'(1);
    assign top    = (depth_q == '0) ? '0 : mem[top_m1[AW-1:0]];
    assign depth  = depth_q;
    assign full   = (depth_q == DW'(DEPTH));

endmodule

// File: rtl/pfx_alu.sv
module pfx_alu #(
    parameter int W = pfx_pkg::DATA_W
) (
    input  logic [1:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] y
);
    import pfx_pkg::*;

    alu_sel_e sel;

    always_comb begin
        sel = op_decode(op);
        unique case (sel)
            SEL_ADD: y = lhs + rhs;
            SEL_SUB: y = lhs - rhs;
            default: y = lhs * rhs;
        endcase
    end

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl #(
    parameter int W     = pfx_pkg::DATA_W,
    parameter int DEPTH = 16,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_valid,
    input  logic [1:0]    tok_kind,
    input  logic [W-1:0]  tok_data,
    output logic          tok_ready,
    input  logic [W-1:0]  stk_top,
    input  logic [DW-1:0] stk_depth,
    input  logic          stk_full,
    output logic          stk_push,
    output logic          stk_pop,
    output logic          stk_clr,
    output logic [W-1:0]  stk_din,
    output logic [1:0]    alu_op,
    output logic [W-1:0]  alu_lhs,
    output logic [W-1:0]  alu_rhs,
    input  logic [W-1:0]  alu_y,
    output logic          res_valid,
    output logic [W-1:0]  res_data,
    output pfx_pkg::err_t err
);
    import pfx_pkg::*;

    ctrl_state_e state_q, state_d;
    logic [1:0]  op_q;
    logic [W-1:0] lhs_q, rhs_q;
    logic        accept;
    logic        done_d;
    err_t        err_d;

    assign tok_ready = (state_q == ST_TAKE);
    assign accept    = tok_valid && tok_ready;

    always_comb begin
        state_d  = state_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        stk_clr  = 1'b0;
        stk_din  = tok_data;
        done_d   = 1'b0;
        err_d    = '0;
        unique case (state_q)
            ST_TAKE: begin
                if (accept) begin
                    case (tok_kind)
                        TK_NUM: begin
                            if (stk_full) begin
                                stk_clr   = 1'b1;
                                err_d.ovf = 1'b1;
                            end else begin
                                stk_push = 1'b1;
                            end
                        end
                        TK_OPER: begin
                            if (stk_depth < DW'(2)) begin
                                stk_clr   = 1'b1;
                                err_d.unf = 1'b1;
                            end else begin
                                state_d = ST_POP_R;
                            end
                        end
                        TK_TERM: begin
                            stk_clr = 1'b1;
                            if (stk_depth == DW'(1)) begin
                                done_d = 1'b1;
                            end else begin
                                err_d.bad = 1'b1;
                            end
                        end
                        default: ; // reserved kind: discarded
                    endcase
                end
            end
            ST_POP_R: begin
                stk_pop = 1'b1;
                state_d = ST_POP_L;
            end
            ST_POP_L: begin
                stk_pop = 1'b1;
                state_d = ST_PUSH;
            end
            ST_PUSH: begin
                stk_push = 1'b1;
                stk_din  = alu_y;
                state_d  = ST_TAKE;
            end
            default: state_d = ST_TAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_TAKE;
            op_q      <= '0;
            lhs_q     <= '0;
            rhs_q     <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            err       <= '0;
        end else begin
            state_q   <= state_d;
            res_valid <= done_d;
            err       <= err_d;
            if (done_d) begin
                res_data <= stk_top;
            end
            if (accept && tok_kind == TK_OPER) begin
                op_q <= tok_data[1:0];
            end
            if (state_q == ST_POP_R) begin
                rhs_q <= stk_top;
            end
            if (state_q == ST_POP_L) begin
                lhs_q <= stk_top;
            end
        end
    end

    assign alu_op  = op_q;
    assign alu_lhs = lhs_q;
    assign alu_rhs = rhs_q;

endmodule

// File: rtl/pfx_eval.sv
module pfx_eval #(
    parameter int W     = pfx_pkg::DATA_W,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tok_valid,
    input  logic [1:0]   tok_kind,
    input  logic [W-1:0] tok_data,
    output logic         tok_ready,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         err_overflow,
    output logic         err_underflow,
    output logic         err_malformed
);
    import pfx_pkg::*;

    localparam int DW = $clog2(DEPTH + 1);

    logic [W-1:0]  stk_top, stk_din;
    logic [DW-1:0] stk_depth;
    logic          stk_full, stk_push, stk_pop, stk_clr;
    logic [1:0]    alu_op;
    logic [W-1:0]  alu_lhs, alu_rhs, alu_y;
    err_t          err;

    pfx_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (stk_push),
        .pop   (stk_pop),
        .clr   (stk_clr),
        .din   (stk_din),
        .top   (stk_top),
        .depth (stk_depth),
        .full  (stk_full)
    );

    pfx_alu #(.W(W)) u_alu (
        .op  (alu_op),
        .lhs (alu_lhs),
        .rhs (alu_rhs),
        .y   (alu_y)
    );

    pfx_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tok_valid (tok_valid),
        .tok_kind  (tok_kind),
        .tok_data  (tok_data),
        .tok_ready (tok_ready),
        .stk_top   (stk_top),
        .stk_depth (stk_depth),
        .stk_full  (stk_full),
        .stk_push  (stk_push),
        .stk_pop   (stk_pop),
        .stk_clr   (stk_clr),
        .stk_din   (stk_din),
        .alu_op    (alu_op),
        .alu_lhs   (alu_lhs),
        .alu_rhs   (alu_rhs),
        .alu_y     (alu_y),
        .res_valid (res_valid),
        .res_data  (res_data),
        .err       (err)
    );

    assign err_overflow  = err.ovf;
    assign err_underflow = err.unf;
    assign err_malformed = err.bad;

endmodule

// File: rtl/pfx_eval_chk.sv
module pfx_eval_chk #(
    parameter int DEPTH = 16,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_valid,
    input logic [1:0]    tok_kind,
    input logic          tok_ready,
    input logic          res_valid,
    input logic          err_overflow,
    input logic          err_underflow,
    input logic          err_malformed,
    input logic [DW-1:0] depth
);
    import pfx_pkg::*;

    logic acc;
    assign acc = tok_valid && tok_ready;

    // R1
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (depth == '0 && tok_ready && !res_valid
                        && !err_overflow && !err_underflow && !err_malformed));

    // R2
    p_push_grows_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_NUM && depth < DW'(DEPTH))
        |=> (depth == $past(depth) + DW'(1) && tok_ready));

    // R3
    p_result_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_TERM && depth == DW'(1)) |=> res_valid ##1 !res_valid);

    // R4: an operator nets one value off the stack four cycles after acceptance
    p_net_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_OPER && depth >= DW'(2))
        |=> ##3 (depth == $past(depth, 4) - DW'(1)));

    // R5
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_NUM && depth == DW'(DEPTH)) |=> err_overflow);

    // R6
    p_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_OPER && depth < DW'(2)) |=> err_underflow);

    // R7
    p_malformed_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_TERM && depth != DW'(1)) |=> err_malformed);

    // R8
    p_busy_window_r8: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_OPER && depth >= DW'(2))
        |=> !tok_ready ##1 !tok_ready ##1 !tok_ready ##1 tok_ready);

    // R9
    p_cleared_after_r9: assert property (@(posedge clk) disable iff (rst)
        (res_valid || err_overflow || err_underflow || err_malformed) |-> depth == '0);

    // R10
    p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (acc && tok_kind == TK_RSVD)
        |=> (depth == $past(depth) && !res_valid
             && !err_overflow && !err_underflow && !err_malformed));

    // R5, R9: depth never exceeds capacity; at most one outcome pulse at a time
    p_depth_bound_r5: assert property (@(posedge clk) disable iff (rst)
        depth <= DW'(DEPTH));
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_valid, err_overflow, err_underflow, err_malformed}));

endmodule

bind pfx_eval pfx_eval_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tok_valid     (tok_valid),
    .tok_kind      (tok_kind),
    .tok_ready     (tok_ready),
    .res_valid     (res_valid),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow),
    .err_malformed (err_malformed),
    .depth         (stk_depth)
);

// File: tb/pfx_eval_test.sv
`timescale 1ns/1ps
module pfx_eval_test;

    localparam int  W     = 16;
    localparam int  DEPTH = 16;
    localparam real CYC   = 8.0;
    localparam int  NV    = 7;

    localparam logic [1:0] K_NUM  = 2'b00;
    localparam logic [1:0] K_OPER = 2'b01;
    localparam logic [1:0] K_TERM = 2'b10;
    localparam logic [1:0] K_RSVD = 2'b11;

    // Expression per row: A B op1 C op2 -> ((A op1 B) op2 C)
    // op codes: 0 add, 1 sub, 2 mul, 3 mul
    localparam logic [15:0] VA  [NV] = '{16'd3, 16'd10, 16'd2, 16'd300, 16'hFFFF, 16'd100, 16'd6};
    localparam logic [15:0] VB  [NV] = '{16'd4, 16'd3,  16'd5, 16'd300, 16'd1,    16'd7,   16'd7};
    localparam logic [15:0] VC  [NV] = '{16'd5, 16'd2,  16'd1, 16'd1,   16'd7,    16'd3,   16'd2};
    localparam logic [1:0]  VO1 [NV] = '{2'd0,  2'd1,   2'd1,  2'd2,    2'd0,     2'd1,    2'd3};
    localparam logic [1:0]  VO2 [NV] = '{2'd2,  2'd2,   2'd0,  2'd0,    2'd1,     2'd1,    2'd0};
    localparam logic [15:0] VX  [NV] = '{16'd35, 16'd14, 16'hFFFE, 16'd24465, 16'hFFF9, 16'd90, 16'd44};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tok_valid = 1'b0;
    logic [1:0]   tok_kind = 2'b00;
    logic [W-1:0] tok_data = '0;
    logic         tok_ready, res_valid, err_overflow, err_underflow, err_malformed;
    logic [W-1:0] res_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    always #(CYC / 2.0) clk = ~clk;

    pfx_eval #(.W(W), .DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst           (rst),
        .tok_valid     (tok_valid),
        .tok_kind      (tok_kind),
        .tok_data      (tok_data),
        .tok_ready     (tok_ready),
        .res_valid     (res_valid),
        .res_data      (res_data),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow),
        .err_malformed (err_malformed)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Called and returns at a falling edge; acceptance is on the rising edge between.
    task automatic send(input logic [1:0] k, input logic [W-1:0] d);
        while (!tok_ready) @(negedge clk);
        tok_valid = 1'b1;
        tok_kind  = k;
        tok_data  = d;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic [W-1:0] exp);
        check_eq(req, "res_valid", {31'd0, res_valid}, 32'd1);
        check_eq(req, "res_data", {16'd0, res_data}, {16'd0, exp});
    endtask

    initial begin
        #(CYC * 50000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: during reset and in the first cycle after it
        repeat (3) @(negedge clk);
        check_eq("R1", "ready in reset", {31'd0, tok_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "ready", {31'd0, tok_ready}, 32'd1);
        check_eq("R1", "flags", {28'd0, res_valid, err_overflow, err_underflow, err_malformed}, 32'd0);

        // Table walk: R2, R3, R4, R8
        for (int i = 0; i < NV; i++) begin
            send(K_NUM, VA[i]);
            check_eq("R2", "ready after number", {31'd0, tok_ready}, 32'd1);
            send(K_NUM, VB[i]);
            send(K_OPER, {14'd0, VO1[i]});
            if (i == 0) begin
                check_eq("R8", "busy 1", {31'd0, tok_ready}, 32'd0);
                @(negedge clk);
                check_eq("R8", "busy 2", {31'd0, tok_ready}, 32'd0);
                @(negedge clk);
                check_eq("R8", "busy 3", {31'd0, tok_ready}, 32'd0);
                @(negedge clk);
                check_eq("R8", "ready back", {31'd0, tok_ready}, 32'd1);
            end
            send(K_NUM, VC[i]);
            send(K_OPER, {14'd0, VO2[i]});
            send(K_TERM, '0);
            expect_result("R4", VX[i]);
            @(negedge clk);
            check_eq("R3", "pulse one cycle", {31'd0, res_valid}, 32'd0);
        end

        // R4: right operand is the top: 20 3 4 * -  = 20 - 12 = 8
        send(K_NUM, 16'd20);
        send(K_NUM, 16'd3);
        send(K_NUM, 16'd4);
        send(K_OPER, 16'd2);
        send(K_OPER, 16'd1);
        send(K_TERM, '0);
        expect_result("R4", 16'd8);

        // R3: single number expression
        send(K_NUM, 16'hBEEF);
        send(K_TERM, '0);
        expect_result("R3", 16'hBEEF);

        // R5: full stack accepted without error, one more overflows
        for (int j = 0; j < DEPTH; j++) begin
            send(K_NUM, 16'(j + 1));
        end
        check_eq("R5", "no overflow at exactly full", {31'd0, err_overflow}, 32'd0);
        send(K_NUM, 16'd77);
        check_eq("R5", "overflow pulse", {31'd0, err_overflow}, 32'd1);
        @(negedge clk);
        check_eq("R5", "overflow one cycle", {31'd0, err_overflow}, 32'd0);
        // R9: stack emptied after overflow
        send(K_NUM, 16'd9);
        send(K_TERM, '0);
        expect_result("R9", 16'd9);

        // R6: operator with one value, then with none
        send(K_NUM, 16'd4);
        send(K_OPER, 16'd0);
        check_eq("R6", "underflow one value", {31'd0, err_underflow}, 32'd1);
        send(K_OPER, 16'd0);
        check_eq("R6", "underflow empty", {31'd0, err_underflow}, 32'd1);
        send(K_NUM, 16'd8);
        send(K_TERM, '0);
        expect_result("R9", 16'd8);

        // R7: two values left, then empty stack
        send(K_NUM, 16'd1);
        send(K_NUM, 16'd2);
        send(K_TERM, '0);
        check_eq("R7", "malformed two left", {31'd0, err_malformed}, 32'd1);
        check_eq("R7", "no result", {31'd0, res_valid}, 32'd0);
        send(K_TERM, '0);
        check_eq("R7", "malformed empty", {31'd0, err_malformed}, 32'd1);
        send(K_NUM, 16'd3);
        send(K_TERM, '0);
        expect_result("R9", 16'd3);

        // R10: reserved kind discarded
        send(K_NUM, 16'd5);
        send(K_RSVD, 16'd99);
        check_eq("R10", "no pulse", {28'd0, res_valid, err_overflow, err_underflow, err_malformed}, 32'd0);
        check_eq("R10", "ready", {31'd0, tok_ready}, 32'd1);
        send(K_TERM, '0);
        expect_result("R10", 16'd5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule